// File: doc/BRIEF.md
# Fractional Audio Master Clock Divider

This block derives an audio master clock from a fast system clock. The clock rate is set by a programmable ratio of a numerator to a denominator, and the accumulator behind it advances on both edges of the system clock. The result is delivered inside the system clock domain. Each system clock cycle carries two edge events, and each event can produce one output clock period. The block reports how many output periods fell in the cycle as `tick_cnt`, and it also raises a one-bit clock enable, `tick`. The average output frequency is 2 · f_clk · num / den exactly. Individual periods vary by at most half a system clock period.

Two worked settings show the range. A 120 MHz clock with 147/3125 gives 11.2896 MHz, which is 256 × 44.1 kHz, and 32/625 gives 12.288 MHz, which is 256 × 48 kHz. A 100 MHz clock with 123/2179 comes very close to 11.2896 MHz. Software chooses the ratio, presents it on `num_in`/`den_in` and pulses `update`. The ratio is taken in only on that strobe, and the strobe also restarts the phase accumulator. `enable` gates operation.

The control is a three-state machine. **IDLE** waits. **RUN** accumulates. **FAULT** holds the output quiet and flags an invalid ratio. The transitions are:
- *load_ok*: a valid update goes to RUN if `enable` is high, and to IDLE otherwise.
- *load_bad*: an invalid update goes to FAULT from any state.
- *start*: IDLE goes to RUN when `enable` is high and a valid ratio has been loaded.
- *stop*: RUN goes to IDLE when `enable` is low.
- FAULT is left only by a valid update.

Top module: `fracdiv_top`

## Requirements
- R1: After reset `tick_cnt` is 0 and `err` is 0. No tick appears until a valid ratio has been loaded, even if `enable` is high.
- R2: On a cycle with `update` high, the registers take `num_in`/`den_in` and the accumulator is cleared. That cycle yields `tick_cnt` = 0, and accumulation begins on the next cycle.
- R3: Each RUN cycle applies two edge events. Over the first N RUN cycles after a clear, the sum of `tick_cnt` is exactly floor(2·N·num/den).
- R4: In every RUN cycle `tick_cnt` lies between floor(2·num/den) and ceil(2·num/den). This bounds period jitter to half a system clock period.
- R5: `tick_cnt` never exceeds 2. `tick` is 1 exactly when `tick_cnt` is non-zero.
- R6: A ratio is invalid when num is 0 or above 256, when den is 0 or above 4096, or when num ≥ den. An invalid update sets `err` to 1 and forces `tick_cnt` to 0 until a valid update, and the valid update clears `err`.
- R7: While `enable` is low, `tick_cnt` is 0 from the following cycle on, and the accumulator is cleared. When `enable` returns, the first cycle yields 0, and counting then restarts as in R3 with the ratio kept.
- R8: A valid update with `enable` low leaves the block idle with no ticks until `enable` rises.
- R9: An update during RUN switches to the new ratio, and the count after it follows R3 for the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both of its edges are counted |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run gate |
| num_in | input | 9 | Numerator presented for loading (1..256) |
| den_in | input | 13 | Denominator presented for loading (1..4096) |
| update | input | 1 | Load strobe for the ratio; clears the accumulator |
| tick_cnt | output | 2 | Output clock periods started in this cycle (0..2) |
| tick | output | 1 | Clock enable: at least one output period in this cycle |
| err | output | 1 | Invalid ratio loaded; output held quiet |

## Verification
A wrong accumulator value shows first as a per-cycle count outside the floor/ceil band. Over a longer window it shows as a running total that drifts from floor(2·N·num/den). The band check catches it within a cycle or two of the fault. The total check catches slower drift after at most one denominator's worth of events. A state machine stuck in the wrong state shows at once: ticks during FAULT or IDLE, missing ticks after a valid load, or an `err` that does not clear. The load and enable paths are each checked on the cycle right after the strobe or edge.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } fd_state_e;
endpackage

// File: rtl/fracdiv_cfg.sv
// Ratio holding registers with range and ordering check.
module fracdiv_cfg #(
    parameter int NUM_W   = 9,
    parameter int DEN_W   = 13,
    parameter int NUM_MAX = 256,
    parameter int DEN_MAX = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             update,
    input  logic [NUM_W-1:0] num_in,
    input  logic [DEN_W-1:0] den_in,
    output logic [NUM_W-1:0] num_q,
    output logic [DEN_W-1:0] den_q,
    output logic             in_valid,
    output logic             cfg_ok,
    output logic             err
);
    localparam int CMP_W = (NUM_W > DEN_W) ? NUM_W : DEN_W;

    logic [CMP_W-1:0] num_ext;
    logic [CMP_W-1:0] den_ext;

    always_comb begin
        num_ext  = CMP_W'(num_in);
        den_ext  = CMP_W'(den_in);
        in_valid = (num_ext != '0) && (num_ext <= CMP_W'(NUM_MAX)) &&
                   (den_ext != '0) && (den_ext <= CMP_W'(DEN_MAX)) &&
                   (num_ext < den_ext);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q  <= '0;
            den_q  <= '0;
            cfg_ok <= 1'b0;
            err    <= 1'b0;
        end else if (update) begin
            num_q  <= num_in;
            den_q  <= den_in;
            cfg_ok <= in_valid;
            err    <= !in_valid;
        end
    end
endmodule

// File: rtl/fracdiv_fsm.sv
// Control: IDLE / RUN / FAULT.
module fracdiv_fsm
    import fracdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      update,
    input  logic      in_valid,
    input  logic      cfg_ok,
    output fd_state_e state_q,
    output logic      step
);
    fd_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (update) begin
            if (in_valid) state_d = enable ? ST_RUN : ST_IDLE;  // load_ok
            else          state_d = ST_FAULT;                   // load_bad
        end else begin
            unique case (state_q)
                ST_IDLE:  if (enable && cfg_ok) state_d = ST_RUN;  // start
                ST_RUN:   if (!enable)          state_d = ST_IDLE; // stop
                ST_FAULT: state_d = ST_FAULT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        step = 1'b0;
        unique case (state_q)
            ST_IDLE:  step = 1'b0;
            ST_RUN:   step = enable && !update;
            ST_FAULT: step = 1'b0;
            default:  step = 1'b0;
        endcase
    end
endmodule

// File: rtl/fracdiv_acc.sv
// Phase accumulator: EDGES edge events per clock, each adds num and
// wraps by den, each wrap is one output period.
module fracdiv_acc #(
    parameter int NUM_W = 9,
    parameter int DEN_W = 13,
    parameter int EDGES = 2,
    parameter int ACC_W = DEN_W + 1,
    parameter int TW    = $clog2(EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [NUM_W-1:0] num_q,
    input  logic [DEN_W-1:0] den_q,
    output logic [ACC_W-1:0] acc_q,
    output logic [TW-1:0]    ticks_q
);
    logic [ACC_W-1:0] part [EDGES+1];
    logic [ACC_W-1:0] sum  [EDGES];
    logic [EDGES-1:0] wrap;
    logic [TW-1:0]    wrap_cnt;

    assign part[0] = acc_q;

    for (genvar e = 0; e < EDGES; e++) begin : g_edge
        assign sum[e]     = part[e] + ACC_W'(num_q);
        assign wrap[e]    = (sum[e] >= ACC_W'(den_q));
        assign part[e+1]  = wrap[e] ? (sum[e] - ACC_W'(den_q)) : sum[e];
    end

    always_comb begin
        wrap_cnt = '0;
        for (int i = 0; i < EDGES; i++) wrap_cnt = wrap_cnt + TW'(wrap[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            ticks_q <= '0;
        end else if (step) begin
            acc_q   <= part[EDGES];
            ticks_q <= wrap_cnt;
        end else begin
            acc_q   <= '0;
            ticks_q <= '0;
        end
    end
endmodule

// File: rtl/fracdiv_top.sv
module fracdiv_top
    import fracdiv_pkg::*;
#(
    parameter int NUM_W   = 9,
    parameter int DEN_W   = 13,
    parameter int NUM_MAX = 256,
    parameter int DEN_MAX = 4096,
    parameter int EDGES   = 2,
    localparam int ACC_W  = DEN_W + 1,
    localparam int TW     = $clog2(EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [NUM_W-1:0] num_in,
    input  logic [DEN_W-1:0] den_in,
    input  logic             update,
    output logic [TW-1:0]    tick_cnt,
    output logic             tick,
    output logic             err
);
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic             in_valid;
    logic             cfg_ok;
    logic             step;
    logic [ACC_W-1:0] acc_q;
    fd_state_e        state_q;

    fracdiv_cfg #(
        .NUM_W(NUM_W), .DEN_W(DEN_W), .NUM_MAX(NUM_MAX), .DEN_MAX(DEN_MAX)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .update(update),
        .num_in(num_in), .den_in(den_in),
        .num_q(num_q), .den_q(den_q),
        .in_valid(in_valid), .cfg_ok(cfg_ok), .err(err)
    );

    fracdiv_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .update(update),
        .in_valid(in_valid), .cfg_ok(cfg_ok),
        .state_q(state_q), .step(step)
    );

    fracdiv_acc #(
        .NUM_W(NUM_W), .DEN_W(DEN_W), .EDGES(EDGES), .ACC_W(ACC_W), .TW(TW)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .step(step),
        .num_q(num_q), .den_q(den_q),
        .acc_q(acc_q), .ticks_q(tick_cnt)
    );

    assign tick = (tick_cnt != '0);
endmodule

// File: rtl/fracdiv_chk.sv
module fracdiv_chk #(
    parameter int ACC_W = 14,
    parameter int DEN_W = 13,
    parameter int TW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             update,
    input logic [TW-1:0]    tick_cnt,
    input logic             tick,
    input logic             err,
    input logic             cfg_ok,
    input logic [ACC_W-1:0] acc_q,
    input logic [DEN_W-1:0] den_q
);
    // R2
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (tick_cnt == '0) && (acc_q == '0));
    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |-> (acc_q < ACC_W'(den_q)));
    // R5
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_cnt <= TW'(2)) && (tick == (tick_cnt != '0)));
    // R6
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (tick_cnt == '0));
    // R7
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (tick_cnt == '0));
    // R1
    unloaded_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> (tick_cnt == '0));
endmodule

bind fracdiv_top fracdiv_chk #(.ACC_W(ACC_W), .DEN_W(DEN_W), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .update(update),
    .tick_cnt(tick_cnt), .tick(tick), .err(err), .cfg_ok(cfg_ok),
    .acc_q(acc_q), .den_q(den_q)
);

// File: tb/fracdiv_top_bench.sv
`timescale 1ns/1ps
module fracdiv_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [8:0]  num_in = '0;
    logic [12:0] den_in = '0;
    logic        update = 1'b0;
    logic [1:0]  tick_cnt;
    logic        tick;
    logic        err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fracdiv_top u_fracdiv_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .num_in(num_in),
        .den_in(den_in), .update(update), .tick_cnt(tick_cnt),
        .tick(tick), .err(err)
    );

    localparam int NV = 8;
    localparam int unsigned V_NUM [NV] = '{147, 32, 123, 1, 255, 256, 1, 3};
    localparam int unsigned V_DEN [NV] = '{3125, 625, 2179, 2, 256, 4096, 4096, 7};
    localparam int unsigned V_LEN [NV] = '{2048, 1500, 2179, 40, 512, 1024, 4096, 700};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input int unsigned n, input int unsigned d, input bit en);
        num_in = 9'(n);
        den_in = 13'(d);
        enable = en;
        update = 1'b1;
        cyc();
        update = 1'b0;
    endtask

    // Counts N running cycles, checks per-cycle band (R4) and total (R3).
    task automatic count_run(input int unsigned n, input int unsigned d, input int unsigned len,
                             input string tag);
        longint total = 0;
        int lo = int'((2 * n) / d);
        int hi = lo + (((2 * n) % d) != 0 ? 1 : 0);
        int bad = 0;
        int bad_val = 0;
        for (int i = 0; i < int'(len); i++) begin
            cyc();
            total += tick_cnt;
            if (int'(tick_cnt) < lo || int'(tick_cnt) > hi || tick != (tick_cnt != 0)) begin
                if (bad == 0) bad_val = int'(tick_cnt);
                bad++;
            end
        end
        chk(bad == 0, {"R4 per-cycle band ", tag}, bad_val, lo);
        chk(total == (longint'(2) * len * n) / d, {"R3 total ", tag}, total,
            (longint'(2) * len * n) / d);
    endtask

    task automatic quiet(input int len, input string req);
        int seen = 0;
        for (int i = 0; i < len; i++) begin
            cyc();
            if (tick_cnt != 0 || tick) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        repeat (3) cyc();
        // R1: reset state
        chk(tick_cnt == 0 && err == 0, "R1 reset outputs", {tick_cnt, err}, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        quiet(20, "R1 no ticks before first load");

        // Table-driven ratios: R2 (load cycle quiet), R3, R4
        for (int v = 0; v < NV; v++) begin
            load(V_NUM[v], V_DEN[v], 1'b1);
            chk(tick_cnt == 0 && err == 0, "R2 load cycle quiet", tick_cnt, 0);
            count_run(V_NUM[v], V_DEN[v], V_LEN[v], $sformatf("%0d/%0d", V_NUM[v], V_DEN[v]));
        end

        // R6: invalid ratios
        load(5, 5, 1'b1);
        chk(err == 1, "R6 num==den sets err", err, 1);
        quiet(40, "R6 num==den quiet");
        load(0, 100, 1'b1);
        chk(err == 1, "R6 num zero sets err", err, 1);
        load(300, 4000, 1'b1);
        chk(err == 1, "R6 num above 256 sets err", err, 1);
        load(10, 5000, 1'b1);
        chk(err == 1, "R6 den above 4096 sets err", err, 1);
        quiet(30, "R6 fault quiet");
        load(3, 7, 1'b1);
        chk(err == 0, "R6 valid load clears err", err, 0);
        count_run(3, 7, 100, "3/7 after fault");

        // R7: disable then re-enable
        enable = 1'b0;
        quiet(25, "R7 disabled quiet");
        enable = 1'b1;
        cyc();
        chk(tick_cnt == 0, "R7 first re-enable cycle quiet", tick_cnt, 0);
        count_run(3, 7, 300, "R7 restart 3/7");

        // R9: retarget mid-run
        load(32, 625, 1'b1);
        chk(tick_cnt == 0, "R9 retarget load cycle", tick_cnt, 0);
        count_run(32, 625, 625, "R9 32/625");

        // R8: valid load with enable low
        load(1, 2, 1'b0);
        quiet(20, "R8 loaded but disabled");
        enable = 1'b1;
        cyc();
        chk(tick_cnt == 0, "R8 start cycle quiet", tick_cnt, 0);
        count_run(1, 2, 30, "R8 1/2");

        finish_up();
    end
endmodule